// File: doc/BRIEF.md
# Tightly-Coupled Memory Wait-State and DMA Arbiter

This block connects a processor's tightly-coupled memory port to a single-ported synchronous memory that is shared with a DMA master. The memory needs one setup cycle before any nonsequential access. Sequential accesses run back to back at full rate. The block has one wait output toward the core. That output covers both the memory's nonsequential wait state and the cycles in which the DMA master owns the memory.

The core's address, chip select, sequential flag and write enable are valid only in the cycle in which the request is made. When a core request is stalled, the block registers its address and direction. It later replays the access from that copy. Core write data is held stable by the core while it is stalled, so the block takes it live when the access completes. The DMA master uses a request/grant handshake. A one-cycle done pulse follows each granted transfer, and read data is returned on a separate DMA read bus.

The memory is assumed to register its read data. A read issued in one cycle therefore returns its data in the next cycle.

Top module: `tcm_dma_arb`

## Requirements
- R1: A core request with the sequential flag low gets exactly one wait state. `core_wait` is high in the request cycle and low in the following cycle, when the core re-presents the access with the sequential flag high. Read data for that access appears on `core_rdata` in the cycle after the completing cycle.
- R2: A core request with the sequential flag high, made after a completed core access, gets no wait state. Its read data appears in the next cycle.
- R3: In a cycle without `core_cs` or a DMA grant, the memory is not accessed and `core_wait` is low, whatever the sequential flag holds. The memory is only ever selected in a cycle with a DMA grant or a core access completing with `core_wait` low.
- R4: When the block is between accesses and `dma_req` is high, the DMA master is granted (`dma_gnt` high in that cycle, memory driven with the DMA fields), even if a core request arrives in the same cycle. Any core request present in a granted cycle sees `core_wait` high.
- R5: A core access whose wait state has already been given completes in the next cycle before any DMA grant. `dma_gnt` stays low in that cycle even with `dma_req` high.
- R6: A core request postponed by DMA is replayed with the address and write enable from its request cycle, even if the core's address bus changes later. A postponed write stores the core write data present in the replay cycle.
- R7: The first core access after one or more DMA grants is treated as nonsequential. It receives one wait state after the last grant, whatever the core's sequential flag holds.
- R8: `dma_done` is high for exactly the cycle after each grant. In that cycle `dma_rdata` carries the word read by a granted DMA read. It is zero when `dma_done` is low.
- R9: During reset, `dma_done` and `mem_cs` are low with idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_cs | input | 1 | Core request valid |
| core_seq | input | 1 | Core sequential flag |
| core_we | input | 1 | Core write enable |
| core_addr | input | AW | Core word address |
| core_wdata | input | DW | Core write data, held while stalled |
| core_rdata | output | DW | Read data to core |
| core_wait | output | 1 | Stall to core |
| dma_req | input | 1 | DMA request, held until granted |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | AW | DMA word address |
| dma_wdata | input | DW | DMA write data |
| dma_gnt | output | 1 | DMA transfer performed this cycle |
| dma_done | output | 1 | One-cycle pulse after a grant |
| dma_rdata | output | DW | DMA read data, valid with dma_done |
| mem_cs | output | 1 | Memory select |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Registered memory read data |

## Verification
The bench builds the block with its defaults: a 6-bit address and a 16-bit data word. A 64-word memory model can then be preloaded with address-derived values, so every read word identifies the address that was actually used. That makes a replay from a stale or live address visible in the returned data. A cycle-by-cycle reference scripts the expected wait, grant and done values of each cycle. It runs through a nonsequential/sequential burst, an idle cycle with a stray sequential flag, DMA collisions that postpone a core read and a core write, a DMA request held off by a completing core access, and back-to-back grants.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,  // between accesses
        ST_HOLD = 2'd1,  // core request parked behind DMA
        ST_FIN  = 2'd2   // core access completes from captured fields
    } arb_st_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LIVE = 2'd1,
        SEL_CAP  = 2'd2,
        SEL_DMA  = 2'd3
    } mux_sel_e;

    typedef struct packed {
        arb_st_e st;
        logic    force_ns;
        logic    done;
    } ctrl_reg_t;

endpackage

// File: rtl/tcm_arb_ctrl.sv
module tcm_arb_ctrl
    import tcm_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     core_cs,
    input  logic     core_seq,
    input  logic     dma_req,
    output logic     core_wait,
    output logic     dma_gnt,
    output logic     dma_done,
    output logic     cap_en,
    output mux_sel_e sel
);

    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        core_wait = 1'b0;
        dma_gnt   = 1'b0;
        cap_en    = 1'b0;
        sel       = SEL_NONE;
        unique case (r_q.st)
            ST_RUN: begin
                if (dma_req) begin
                    dma_gnt  = 1'b1;
                    sel      = SEL_DMA;
                    r_d.done = 1'b1;
                    if (core_cs) begin
                        core_wait = 1'b1;
                        cap_en    = 1'b1;
                        r_d.st    = ST_HOLD;
                    end else begin
                        r_d.force_ns = 1'b1;
                    end
                end else if (core_cs) begin
                    if (!core_seq || r_q.force_ns) begin
                        core_wait = 1'b1;
                        cap_en    = 1'b1;
                        r_d.st    = ST_FIN;
                    end else begin
                        sel          = SEL_LIVE;
                        r_d.force_ns = 1'b0;
                    end
                end
            end
            ST_HOLD: begin
                core_wait = 1'b1;
                if (dma_req) begin
                    dma_gnt  = 1'b1;
                    sel      = SEL_DMA;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                sel          = SEL_CAP;
                r_d.st       = ST_RUN;
                r_d.force_ns = 1'b0;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_RUN;
            r_q.force_ns <= 1'b0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dma_done = r_q.done;

endmodule

// File: rtl/tcm_req_capture.sv
module tcm_req_capture #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    output logic [AW-1:0] cap_addr,
    output logic          cap_we
);

    logic [AW-1:0] addr_d, addr_q;
    logic          we_d, we_q;

    always_comb begin
        addr_d = addr_q;
        we_d   = we_q;
        if (cap_en) begin
            addr_d = core_addr;
            we_d   = core_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else begin
            addr_q <= addr_d;
            we_q   <= we_d;
        end
    end

    assign cap_addr = addr_q;
    assign cap_we   = we_q;

endmodule

// File: rtl/tcm_mem_mux.sv
module tcm_mem_mux
    import tcm_arb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  mux_sel_e      sel,
    input  logic [AW-1:0] core_addr,
    input  logic          core_we,
    input  logic [DW-1:0] core_wdata,
    input  logic [AW-1:0] cap_addr,
    input  logic          cap_we,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_we,
    input  logic [DW-1:0] dma_wdata,
    output logic          mem_cs,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    always_comb begin
        mem_cs    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = core_wdata;
        unique case (sel)
            SEL_LIVE: begin
                mem_cs   = 1'b1;
                mem_we   = core_we;
                mem_addr = core_addr;
            end
            SEL_CAP: begin
                mem_cs   = 1'b1;
                mem_we   = cap_we;
                mem_addr = cap_addr;
            end
            SEL_DMA: begin
                mem_cs    = 1'b1;
                mem_we    = dma_we;
                mem_addr  = dma_addr;
                mem_wdata = dma_wdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tcm_dma_arb.sv
module tcm_dma_arb
    import tcm_arb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_cs,
    input  logic          core_seq,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    output logic          core_wait,
    input  logic          dma_req,
    input  logic          dma_we,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    output logic          dma_gnt,
    output logic          dma_done,
    output logic [DW-1:0] dma_rdata,
    output logic          mem_cs,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic          cap_en;
    mux_sel_e      sel;
    logic [AW-1:0] cap_addr;
    logic          cap_we;

    tcm_arb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_cs   (core_cs),
        .core_seq  (core_seq),
        .dma_req   (dma_req),
        .core_wait (core_wait),
        .dma_gnt   (dma_gnt),
        .dma_done  (dma_done),
        .cap_en    (cap_en),
        .sel       (sel)
    );

    tcm_req_capture #(.AW(AW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .core_addr (core_addr),
        .core_we   (core_we),
        .cap_addr  (cap_addr),
        .cap_we    (cap_we)
    );

    tcm_mem_mux #(.AW(AW), .DW(DW)) u_mux (
        .sel        (sel),
        .core_addr  (core_addr),
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .cap_addr   (cap_addr),
        .cap_we     (cap_we),
        .dma_addr   (dma_addr),
        .dma_we     (dma_we),
        .dma_wdata  (dma_wdata),
        .mem_cs     (mem_cs),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign core_rdata = mem_rdata;
    assign dma_rdata  = dma_done ? mem_rdata : '0;

endmodule

// File: rtl/tcm_dma_arb_chk.sv
module tcm_dma_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic core_cs,
    input logic core_wait,
    input logic dma_gnt,
    input logic dma_done,
    input logic mem_cs
);

    // R8: a grant is always followed by the done pulse
    assert_done_after_gnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |=> dma_done);

    // R8: done never appears without a grant one cycle earlier
    assert_done_needs_gnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |-> $past(dma_gnt));

    // R4: the core is stalled whenever DMA owns the memory
    assert_core_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && core_cs) |-> core_wait);

    // R3: memory only selected for a grant or a completing core access
    assert_mem_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> (dma_gnt || !core_wait));

    // R5: after a plain wait state the core access finishes before any grant
    assert_inflight_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cs && core_wait && !dma_gnt) |=> !dma_gnt);

    // R7: the core cycle right after a grant is still stalled
    assert_post_dma_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dma_gnt) && !dma_gnt && core_cs) |-> core_wait);

endmodule

bind tcm_dma_arb tcm_dma_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_cs   (core_cs),
    .core_wait (core_wait),
    .dma_gnt   (dma_gnt),
    .dma_done  (dma_done),
    .mem_cs    (mem_cs)
);

// File: tb/tcm_dma_arb_tb.sv
module tcm_dma_arb_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_cs = 1'b0, core_seq = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          core_wait;
    logic          dma_req = 1'b0, dma_we = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [DW-1:0] dma_wdata = '0;
    logic          dma_gnt, dma_done;
    logic [DW-1:0] dma_rdata;
    logic          mem_cs, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem_arr [DEPTH];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tcm_dma_arb #(.AW(AW), .DW(DW)) u_dut (.*);

    // memory model: registered read, write on select
    initial for (int i = 0; i < DEPTH; i++) mem_arr[i] = DW'(16'hA000 + i);
    always @(posedge clk) begin
        if (mem_cs) begin
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare just before the next rising edge
    task automatic cyc(input bit c_cs, input bit c_seq, input bit c_we,
                       input int c_addr, input int c_wd,
                       input bit d_req, input bit d_we, input int d_addr, input int d_wd,
                       input int e_wait, input int e_gnt, input int e_done,
                       input int e_crd, input int e_drd, input int e_mcs,
                       input string tag);
        @(negedge clk);
        core_cs = c_cs; core_seq = c_seq; core_we = c_we;
        core_addr = AW'(c_addr); core_wdata = DW'(c_wd);
        dma_req = d_req; dma_we = d_we; dma_addr = AW'(d_addr); dma_wdata = DW'(d_wd);
        #8;
        chk({tag, " wait"}, int'(core_wait), e_wait);
        chk({tag, " gnt"}, int'(dma_gnt), e_gnt);
        chk({tag, " done"}, int'(dma_done), e_done);
        if (e_crd >= 0) chk({tag, " core_rdata"}, int'(core_rdata), e_crd);
        if (e_drd >= 0) chk({tag, " dma_rdata"}, int'(dma_rdata), e_drd);
        if (e_mcs >= 0) chk({tag, " mem_cs"}, int'(mem_cs), e_mcs);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #8;
        chk("R9 reset done", int'(dma_done), 0);
        chk("R9 reset mem_cs", int'(mem_cs), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // burst: nonseq A=4, re-present, seq A=5, idle with stray seq flag
        cyc(1,0,0, 4,0,      0,0,0,0,  1,0,0, -1,-1,0, "R1 nonseq wait");
        cyc(1,1,0, 4,0,      0,0,0,0,  0,0,0, -1,-1,1, "R1 completes");
        cyc(1,1,0, 5,0,      0,0,0,0,  0,0,0, 16'hA004,-1,1, "R2 seq no wait");
        cyc(0,1,0, 9,0,      0,0,0,0,  0,0,0, 16'hA005,-1,0, "R3 idle");

        // DMA collides with core read of 8; core bus changes to 63 afterwards
        cyc(1,0,0, 8,0,      1,0,20,0, 1,1,0, -1,-1,1, "R4 dma wins");
        cyc(1,1,0, 63,0,     0,0,0,0,  1,0,1, -1,16'hA014,0, "R7 post-dma wait");
        cyc(1,1,0, 63,0,     0,0,0,0,  0,0,0, -1,0,1, "R6 replay");
        cyc(0,0,0, 0,0,      0,0,0,0,  0,0,0, 16'hA008,-1,0, "R6 captured addr");

        // core write to 10 in flight holds DMA off; then DMA postpones write to 12
        cyc(1,0,1, 10,16'h1234, 0,0,0,0, 1,0,0, -1,-1,0, "R1 write wait");
        cyc(1,1,1, 10,16'h1234, 1,0,10,0, 0,0,0, -1,-1,1, "R5 inflight first");
        cyc(1,0,1, 12,16'hBEEF, 1,0,10,0, 1,1,0, -1,-1,1, "R4 dma wins write");
        cyc(1,1,1, 40,16'hBEEF, 0,0,0,0,  1,0,1, -1,16'h1234,0, "R8 dma read data");
        cyc(1,1,1, 40,16'hBEEF, 0,0,0,0,  0,0,0, -1,-1,1, "R6 replay write");
        cyc(1,1,0, 12,0,     0,0,0,0,  0,0,0, -1,-1,1, "R2 seq after replay");
        cyc(0,0,0, 0,0,      0,0,0,0,  0,0,0, 16'hBEEF,-1,0, "R6 live wdata");

        // DMA write alone, then a sequential-flagged core read is forced nonseq
        cyc(0,1,0, 0,0,      1,1,30,16'h5555, 0,1,0, -1,-1,1, "R4 dma idle core");
        cyc(1,1,0, 30,0,     0,0,0,0,  1,0,1, -1,-1,0, "R7 forced nonseq");
        cyc(1,1,0, 30,0,     0,0,0,0,  0,0,0, -1,0,1, "R7 completes");
        cyc(0,0,0, 0,0,      0,0,0,0,  0,0,0, 16'h5555,-1,0, "R8 dma write landed");

        // back-to-back DMA grants while core read of 2 is parked
        cyc(1,0,0, 2,0,      1,0,3,0,  1,1,0, -1,-1,1, "R4 first grant");
        cyc(1,1,0, 50,0,     1,0,4,0,  1,1,1, -1,16'hA003,1, "R8 second grant");
        cyc(1,1,0, 50,0,     0,0,0,0,  1,0,1, -1,16'hA004,0, "R7 wait after last");
        cyc(1,1,0, 50,0,     0,0,0,0,  0,0,0, -1,-1,1, "R6 replay after two");
        cyc(0,0,0, 0,0,      0,0,0,0,  0,0,0, 16'hA002,-1,0, "R6 data after two");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule